// File: doc/BRIEF.md
# Orientation-Swapping Transpose Store

This block sits between a row-direction transform stage and a column-direction transform stage. It takes one square block of signed samples (8x8 of 10 bits by default), delivered two samples per cycle in row order. It returns the same samples two per cycle in column order. Storage is a single set of 64 registers. Each block is written along the addresses that the previous block is being read from, so the address map flips from one block to the next. No second bank is needed.

Reading of a block begins once its last pair is stored. The output then streams without gaps for 32 cycles. While a block streams out, the next block may be written behind the read position, and the input never has to wait. A comparator between the write and read positions keeps input ready low whenever a write would land on a location that is still unread.

Top module: `tbuf_xpose`

## Requirements
- R1: While rst_n is low, out_valid and in_ready are low. in_ready is high from the second rising clock edge after rst_n rises, and out_valid stays low.
- R2: out_valid stays low until 32 pairs of a block have been accepted, where a pair is accepted on a rising edge with in_valid and in_ready high. The first output pair of a block that follows an idle output is valid after the edge that follows the accepting edge of that block's last pair.
- R3: Within a block, input pair p carries linear indices k=2p (lane 0) and k=2p+1 (lane 1). Output pair m carries, on lane 0, the input sample at linear index T(2m) and, on lane 1, the one at T(2m+1), where T(k) = (k mod 8)*8 + floor(k/8).
- R4: Sample values pass unchanged across the full signed range -512 to 511. Lane l occupies bits [10*l+9 : 10*l] of both in_data and out_data.
- R5: The 32 output pairs of a block appear on 32 consecutive cycles, so every run of out_valid lasts a whole multiple of 32 cycles.
- R6: in_ready stays high while a block is being read out, so blocks may be written back to back. The output then stays valid across block boundaries, and a write never targets a pair position beyond the one being read.
- R7: Cycles with in_valid low accept nothing, whatever in_data carries.
- R8: R3 holds for even-numbered and odd-numbered blocks alike, even though they are stored with opposite address maps, for any sequence of consecutive blocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Input pair present |
| in_data | input | 20 | Two signed 10-bit samples, lane 0 in the low bits |
| in_ready | output | 1 | Input pair will be taken at the next rising edge |
| out_valid | output | 1 | Output pair present |
| out_data | output | 20 | Two signed 10-bit samples in transposed order, lane 0 in the low bits |

## Verification
The hardest case to reach is the write of block n+1 landing in the same cycle as, or one pair behind, the read of block n at the same storage location. This exposes the ordering between the output register capture and the array update. The stimulus reaches it by streaming four blocks back to back with no idle cycles, so every pair of each later block is written in the exact cycle its location is being read. Gapped blocks, with data lines toggling while in_valid is low, and a block of extreme values cover both address maps and the ignore rule.

// File: rtl/tbuf_pkg.sv
package tbuf_pkg;
  // Address map used for a block: natural order or swapped row/column
  typedef enum logic {
    ORI_ROW = 1'b0,
    ORI_COL = 1'b1
  } ori_e;
endpackage

// File: rtl/tbuf_rst_sync.sv
module tbuf_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= 2'b00;
    else        sh_q <= {sh_q[0], 1'b1};
  end

  assign rst_sync_n = sh_q[1];
endmodule

// File: rtl/tbuf_wr_ctrl.sv
module tbuf_wr_ctrl
  import tbuf_pkg::*;
#(
  parameter int N     = 8,
  parameter int LANES = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        in_valid,
  input  logic                        rd_busy,
  input  logic [$clog2(N*N/LANES)-1:0] rd_pos,
  output logic                        in_ready,
  output logic                        wr_en,
  output logic                        blk_done,
  output ori_e                        wr_ori,
  output logic [$clog2(N*N/LANES)-1:0] wr_pos,
  output logic [LANES-1:0][$clog2(N*N)-1:0] wr_addr
);
  localparam int PAIRS = N * N / LANES;
  localparam int PW    = $clog2(PAIRS);
  localparam int AW    = $clog2(N * N);
  localparam int LG    = $clog2(N);

  logic [PW-1:0] pos_q, pos_d;
  ori_e          ori_q, ori_d;
  logic          last;

  // Guard: the write may not pass the read position of the previous block
  assign in_ready = rst_n && (!rd_busy || (pos_q <= rd_pos));
  assign wr_en    = in_valid && in_ready;
  assign last     = (pos_q == PW'(PAIRS - 1));
  assign blk_done = wr_en && last;

  always_comb begin
    pos_d = last ? '0 : pos_q + 1'b1;
    ori_d = ori_q;
    if (last) ori_d = (ori_q == ORI_ROW) ? ORI_COL : ORI_ROW;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q <= '0;
      ori_q <= ORI_ROW;
    end else if (wr_en) begin
      pos_q <= pos_d;
      ori_q <= ori_d;
    end
  end

  for (genvar l = 0; l < LANES; l++) begin : g_addr
    logic [AW-1:0] lin;
    assign lin        = AW'(pos_q * LANES + l);
    assign wr_addr[l] = (ori_q == ORI_COL) ? {lin[LG-1:0], lin[AW-1:LG]} : lin;
  end

  assign wr_ori = ori_q;
  assign wr_pos = pos_q;
endmodule

// File: rtl/tbuf_rd_ctrl.sv
module tbuf_rd_ctrl
  import tbuf_pkg::*;
#(
  parameter int N     = 8,
  parameter int LANES = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        blk_done,
  input  ori_e                        wr_ori,
  output logic                        rd_busy,
  output logic [$clog2(N*N/LANES)-1:0] rd_pos,
  output logic [LANES-1:0][$clog2(N*N)-1:0] rd_addr
);
  localparam int PAIRS = N * N / LANES;
  localparam int PW    = $clog2(PAIRS);
  localparam int AW    = $clog2(N * N);
  localparam int LG    = $clog2(N);

  logic          busy_q, busy_d;
  logic [PW-1:0] pos_q, pos_d;
  ori_e          ori_q, ori_d;
  logic          upd;

  assign upd = blk_done || busy_q;

  always_comb begin
    if (blk_done) begin
      busy_d = 1'b1;
      pos_d  = '0;
      ori_d  = wr_ori;
    end else begin
      busy_d = (pos_q != PW'(PAIRS - 1));
      pos_d  = pos_q + 1'b1;
      ori_d  = ori_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      pos_q  <= '0;
      ori_q  <= ORI_ROW;
    end else if (upd) begin
      busy_q <= busy_d;
      pos_q  <= pos_d;
      ori_q  <= ori_d;
    end
  end

  // Read with the map opposite to the one the block was written with
  for (genvar l = 0; l < LANES; l++) begin : g_addr
    logic [AW-1:0] lin;
    assign lin        = AW'(pos_q * LANES + l);
    assign rd_addr[l] = (ori_q == ORI_COL) ? lin : {lin[LG-1:0], lin[AW-1:LG]};
  end

  assign rd_busy = busy_q;
  assign rd_pos  = pos_q;
endmodule

// File: rtl/tbuf_store.sv
module tbuf_store #(
  parameter int W     = 10,
  parameter int N     = 8,
  parameter int LANES = 2
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            wr_en,
  input  logic [LANES-1:0][$clog2(N*N)-1:0] wr_addr,
  input  logic [LANES*W-1:0]              wr_data,
  input  logic                            rd_en,
  input  logic [LANES-1:0][$clog2(N*N)-1:0] rd_addr,
  output logic                            rd_valid,
  output logic [LANES*W-1:0]              rd_data
);
  localparam int DEPTH = N * N;

  logic [W-1:0]       mem_q [DEPTH];
  logic [W-1:0]       mem_d [DEPTH];
  logic [LANES*W-1:0] dat_d, dat_q;
  logic               vld_q;

  always_comb begin
    for (int i = 0; i < DEPTH; i++) mem_d[i] = mem_q[i];
    for (int l = 0; l < LANES; l++) mem_d[wr_addr[l]] = wr_data[l*W +: W];
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= mem_d[i];
    end
  end

  // Reads see the array before this cycle's write lands
  for (genvar l = 0; l < LANES; l++) begin : g_rd
    assign dat_d[l*W +: W] = mem_q[rd_addr[l]];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      dat_q <= '0;
    end else begin
      vld_q <= rd_en;
      if (rd_en) dat_q <= dat_d;
    end
  end

  assign rd_valid = vld_q;
  assign rd_data  = dat_q;
endmodule

// File: rtl/tbuf_xpose.sv
module tbuf_xpose
  import tbuf_pkg::*;
#(
  parameter int W     = 10,
  parameter int N     = 8,
  parameter int LANES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic [LANES*W-1:0] in_data,
  output logic               in_ready,
  output logic               out_valid,
  output logic [LANES*W-1:0] out_data
);
  localparam int PW = $clog2(N * N / LANES);
  localparam int AW = $clog2(N * N);

  logic                      rs_n;
  logic                      wr_en, blk_done, rd_busy;
  ori_e                      wr_ori;
  logic [PW-1:0]             wr_pos, rd_pos;
  logic [LANES-1:0][AW-1:0]  wr_addr, rd_addr;

  tbuf_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rs_n)
  );

  tbuf_wr_ctrl #(.N(N), .LANES(LANES)) u_wr (
    .clk      (clk),
    .rst_n    (rs_n),
    .in_valid (in_valid),
    .rd_busy  (rd_busy),
    .rd_pos   (rd_pos),
    .in_ready (in_ready),
    .wr_en    (wr_en),
    .blk_done (blk_done),
    .wr_ori   (wr_ori),
    .wr_pos   (wr_pos),
    .wr_addr  (wr_addr)
  );

  tbuf_rd_ctrl #(.N(N), .LANES(LANES)) u_rd (
    .clk      (clk),
    .rst_n    (rs_n),
    .blk_done (blk_done),
    .wr_ori   (wr_ori),
    .rd_busy  (rd_busy),
    .rd_pos   (rd_pos),
    .rd_addr  (rd_addr)
  );

  tbuf_store #(.W(W), .N(N), .LANES(LANES)) u_mem (
    .clk      (clk),
    .rst_n    (rs_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (in_data),
    .rd_en    (rd_busy),
    .rd_addr  (rd_addr),
    .rd_valid (out_valid),
    .rd_data  (out_data)
  );
endmodule

// File: rtl/tbuf_xpose_chk.sv
module tbuf_xpose_chk #(
  parameter int N     = 8,
  parameter int LANES = 2
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         in_valid,
  input logic                         in_ready,
  input logic                         out_valid,
  input logic                         wr_en,
  input logic                         rd_busy,
  input logic [$clog2(N*N/LANES)-1:0] wr_pos,
  input logic [$clog2(N*N/LANES)-1:0] rd_pos
);
  localparam int PAIRS = N * N / LANES;
  localparam int PW    = $clog2(PAIRS);

  logic [PW:0]  acc_q;
  logic [15:0]  run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      run_q <= '0;
    end else begin
      if (wr_en && (acc_q < (PW+1)'(PAIRS))) acc_q <= acc_q + 1'b1;
      run_q <= out_valid ? run_q + 1'b1 : 16'd0;
    end
  end

  AST_NO_EARLY_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (acc_q == (PW+1)'(PAIRS)));                          // R2
  AST_READ_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_busy) |=> out_valid);                                      // R2
  AST_RUN_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(out_valid) |-> ((run_q[PW-1:0] == '0) && (run_q != 16'd0))); // R5
  AST_NO_OVERWRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && rd_busy) |-> (wr_pos <= rd_pos));                         // R6
  AST_STREAM_READY: assert property (@(posedge clk) disable iff (!rst_n)
    rd_busy |-> in_ready);                                              // R6
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(wr_pos));                                     // R7
endmodule

bind tbuf_xpose tbuf_xpose_chk #(.N(N), .LANES(LANES)) i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .wr_en     (wr_en),
  .rd_busy   (rd_busy),
  .wr_pos    (wr_pos),
  .rd_pos    (rd_pos)
);

// File: tb/test_tbuf_xpose.sv
`timescale 1ns/100ps
module test_tbuf_xpose;
  localparam int W = 10;
  localparam int L = 2;
  localparam int PAIRS = 32;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           in_valid = 1'b0;
  logic [L*W-1:0] in_data = '0;
  logic           in_ready, out_valid;
  logic [L*W-1:0] out_data;

  int tests = 0, fails = 0, stall_cnt = 0;
  int in_mem [0:15][0:63];
  int blk_in = 0, ip = 0, ob = 0, op = 0, ncyc = 0, done_n = 0, run = 0, max_run = 0;
  logic prev_v = 1'b0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  tbuf_xpose i_tbuf_xpose (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .out_valid(out_valid), .out_data(out_data)
  );

  function automatic int tp(int k);
    return (k % 8) * 8 + k / 8;
  endfunction

  function automatic int sval(int b, int k);
    if (b == 5) begin
      if (k % 3 == 0) return -512;
      if (k % 3 == 1) return 511;
      return k * 7 - 200;
    end
    return ((b * 37 + k * 11 + 5) % 1024) - 512;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send_block(int b, bit gaps);
    for (int p = 0; p < PAIRS; p++) begin
      int g;
      bit ok;
      g = !gaps ? 0 : (p % 3 == 1) ? 1 : (p % 7 == 0) ? 2 : 0;
      repeat (g) begin
        in_valid = 1'b0;
        in_data  = 20'hA5A5A ^ 20'(p);   // R7: junk while idle
        @(posedge clk); #1;
      end
      in_valid = 1'b1;
      in_data  = {W'(sval(b, 2*p+1)), W'(sval(b, 2*p))};
      do begin
        @(negedge clk);
        ok = in_ready;
        if (!ok) stall_cnt++;
        @(posedge clk); #1;
      end while (!ok);
    end
    in_valid = 1'b0;
  endtask

  // Monitor: captures accepted input and checks output against the transpose
  always @(negedge clk) begin
    ncyc++;
    if (rst_n && in_valid && in_ready) begin
      in_mem[blk_in % 16][2*ip]   = int'($signed(in_data[W-1:0]));
      in_mem[blk_in % 16][2*ip+1] = int'($signed(in_data[2*W-1:W]));
      if (ip == PAIRS - 1) begin
        ip = 0; blk_in++; done_n = ncyc;
      end else ip++;
    end
    if (out_valid) begin
      int e0, e1, a0, a1;
      if (!prev_v) chk(ncyc == done_n + 2, "R2 latency", ncyc - done_n, 2);
      e0 = in_mem[ob % 16][tp(2*op)];
      e1 = in_mem[ob % 16][tp(2*op+1)];
      a0 = int'($signed(out_data[W-1:0]));
      a1 = int'($signed(out_data[2*W-1:W]));
      chk(a0 == e0 && a1 == e1, (ob % 2) ? "R8 odd block R4" : "R3 even block R4",
          a1 * 1024 + a0, e1 * 1024 + e0);
      if (op == PAIRS - 1) begin op = 0; ob++; end else op++;
      run++;
      if (run > max_run) max_run = run;
    end else if (prev_v) begin
      chk(run % PAIRS == 0, "R5 run length", run, PAIRS);
      run = 0;
    end
    prev_v = out_valid;
  end

  initial begin
    #(200000 * 5.0);
    if (!finished) begin
      fails++; tests++;
      $display("FAIL watchdog actual=%0d expected=%0d", ob, 6);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(out_valid == 1'b0, "R1 valid in reset", int'(out_valid), 0);
    chk(in_ready == 1'b0, "R1 ready in reset", int'(in_ready), 0);
    @(posedge clk); #1;
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(in_ready == 1'b1, "R1 ready after reset", int'(in_ready), 1);
    chk(out_valid == 1'b0, "R1 valid after reset", int'(out_valid), 0);
    @(posedge clk); #1;

    send_block(0, 1'b1);
    @(negedge clk);
    chk(out_valid == 1'b0, "R2 not yet valid", int'(out_valid), 0);
    @(posedge clk); #1;
    repeat (45) begin @(posedge clk); #1; end
    chk(ob == 1, "R2 first block out", ob, 1);

    stall_cnt = 0;
    for (int b = 1; b <= 4; b++) send_block(b, 1'b0);
    chk(stall_cnt == 0, "R6 no stall back-to-back", stall_cnt, 0);
    repeat (45) begin @(posedge clk); #1; end
    chk(max_run >= 4 * PAIRS, "R6 continuous output", max_run, 4 * PAIRS);

    send_block(5, 1'b1);
    repeat (45) begin @(posedge clk); #1; end
    @(negedge clk);
    chk(out_valid == 1'b0, "R5 idle after last", int'(out_valid), 0);
    chk(blk_in == 6, "R7 accepted blocks", blk_in, 6);
    chk(ob == 6, "R8 blocks out", ob, 6);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule